// File: doc/BRIEF.md
# Calendar Time Counter with Alarm Match

This block holds a wall-clock calendar: seconds, minutes, hours, day of week, day of month, month and a two-digit year. On every one-second strobe it advances the count by one second, with full month-length and leap-year rollover. Internally every field is kept in binary. Each field is presented as a byte that is either packed decimal (tens digit in the upper nibble) or plain binary, and hours are shown in 24-hour form or in 12-hour form with a PM flag. A control bit selects each choice and takes effect at once.

Each advance is framed by an update-busy indication that stays high for a fixed number of clock cycles before the new time appears. Advances are suppressed while the hold bit is set or while the oscillator-mode field is anything other than the running code. When an advance finishes, the block compares the new seconds, minutes and hours against three alarm bytes, where the 0xC0 don't-care code is allowed, and emits a one-cycle flag byte meant to be ORed into an interrupt-flag register. Software loads fields through a simple write port, using the current encoding.

The controller is a three-state machine. `ST_IDLE` waits for a strobe. Strobe while running → `ST_UPD`. `ST_UPD` holds the busy flag for `UIP_CYCLES` cycles. If the hold bit rises it returns to `ST_IDLE` without advancing (abort). When the count ends it loads the next time and moves to `ST_POST` (commit). `ST_POST` lasts one cycle, emits the flags for the new time and goes back to `ST_IDLE`.

Top module: `cal_time_counter`

## Requirements
- R1: With `ctl_binary`=0, every field byte is packed decimal: bits 7:4 hold the tens digit and bits 3:0 the ones digit. Written bytes are decoded the same way.
- R2: With `ctl_binary`=1, field bytes are plain binary values. Changing `ctl_binary` re-encodes the outputs without changing the stored time.
- R3: With `ctl_24h`=0, the hour byte shows 12, 1..11 in the low bits, and bit 7 set means PM. Midnight reads 12 AM and noon reads 12 PM. A written hour byte is decoded with the same rule.
- R4: With `ctl_24h`=1, hours run 0..23. Seconds and minutes wrap from 59 to 0 with a carry.
- R5: Day of week counts 1..7 and returns to 1 after 7 when the day changes.
- R6: Day of month rolls over after the month length: 31,28,31,30,31,30,31,31,30,31,30,31. February has 29 days when the full year (BASE_YEAR plus the year byte) is divisible by 4, except century years that are not divisible by 400. Month wraps from 12 to 1, and the year wraps from 99 to 0.
- R7: A strobe is ignored unless `osc_sel` equals 3'b010. The time stays unchanged and `uip_o` stays low.
- R8: While `ctl_set` is 1, strobes cause no advance. Raising `ctl_set` during an update drops `uip_o` on the next cycle and cancels that advance.
- R9: `uip_o` rises in the cycle after an accepted strobe and stays high for exactly `UIP_CYCLES` cycles. The advanced time is visible in the cycle after `uip_o` falls.
- R10: In the cycle after the advance, if `ctl_alarm_en`=1 and each of the three alarm bytes either has bits 7:6 = 11 or equals the newly encoded field byte, `evt_flags` includes 0xA0.
- R11: In the same cycle, if `ctl_upd_en`=1, `evt_flags` includes 0x90. At all other times `evt_flags` is 0.
- R12: A write with `wr_en`=1 stores the decoded `wr_data` into the field chosen by `wr_field` (0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year) on the next clock edge, whether or not `ctl_set` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; time becomes 00:00:00, day 1, weekday 1, month 1, year 0 |
| sec_tick | input | 1 | One-cycle once-per-second strobe |
| ctl_set | input | 1 | Hold: suppress advances, abort an update in progress |
| ctl_binary | input | 1 | 1 = binary field bytes, 0 = packed decimal |
| ctl_24h | input | 1 | 1 = 24-hour, 0 = 12-hour with PM in bit 7 |
| ctl_alarm_en | input | 1 | Enable alarm flag |
| ctl_upd_en | input | 1 | Enable update-finished flag |
| osc_sel | input | 3 | Oscillator mode; 3'b010 means running |
| wr_en | input | 1 | Field write strobe |
| wr_field | input | 3 | Field index for the write |
| wr_data | input | 8 | Field byte in the current encoding |
| alm_sec | input | 8 | Seconds alarm byte |
| alm_min | input | 8 | Minutes alarm byte |
| alm_hour | input | 8 | Hours alarm byte |
| sec_o | output | 8 | Seconds byte |
| min_o | output | 8 | Minutes byte |
| hour_o | output | 8 | Hours byte |
| wday_o | output | 8 | Day-of-week byte |
| mday_o | output | 8 | Day-of-month byte |
| mon_o | output | 8 | Month byte |
| year_o | output | 8 | Year byte |
| uip_o | output | 1 | Update busy |
| evt_flags | output | 8 | One-cycle flag byte to OR into an interrupt-flag register |

## Verification
The bench focuses on the carry chain at its edges. It checks a New Year's Eve second that ripples through every field, February 28 in a leap year, a plain year and the year-2000 century case, and the end of a 30-day month. A wrong month table or leap rule would show the wrong day, and a broken weekday wrap would show 8 or 0. In 12-hour mode it checks the 11→12 crossing on both AM and PM sides and the 12→1 PM step; a design that uses hour modulo 12 without correction would show 0, or flip the PM bit at the wrong point. It also checks that the hold bit and non-running oscillator codes freeze the time, that an update aborted by the hold bit neither advances the time nor keeps the busy flag up, and that the alarm match honours don't-care bytes and the enable bit. A bad comparator would raise the alarm on mismatching seconds or miss a wildcard.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam logic [2:0] OSC_RUN   = 3'b010;
    localparam int         NUM_FLD   = 7;
    localparam int         FLD_SEC   = 0;
    localparam int         FLD_MIN   = 1;
    localparam int         FLD_HOUR  = 2;
    localparam int         FLD_WDAY  = 3;
    localparam int         FLD_MDAY  = 4;
    localparam int         FLD_MON   = 5;
    localparam int         FLD_YEAR  = 6;
    localparam logic [7:0] EVT_ALARM = 8'hA0;
    localparam logic [7:0] EVT_UPD   = 8'h90;
    localparam logic [1:0] DONT_CARE = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_UPD  = 2'd1,
        ST_POST = 2'd2
    } cal_state_e;

    typedef struct packed {
        logic [5:0] sec;
        logic [5:0] min;
        logic [4:0] hour;
        logic [2:0] wday;
        logic [4:0] mday;
        logic [3:0] mon;
        logic [6:0] year;
    } cal_time_t;

    function automatic logic [7:0] enc_val(input logic [6:0] v, input logic bin);
        logic [6:0] tens;
        logic [6:0] ones;
        tens = v / 7'd10;
        ones = v % 7'd10;
        return bin ? {1'b0, v} : {tens[3:0], ones[3:0]};
    endfunction

    function automatic logic [6:0] dec_val(input logic [7:0] b, input logic bin);
        return bin ? b[6:0] : (7'(b[7:4]) * 7'd10 + 7'(b[3:0]));
    endfunction

endpackage

// File: rtl/cal_rollover.sv
module cal_rollover
    import cal_pkg::*;
#(
    parameter int BASE_YEAR = 2000
) (
    input  cal_time_t cur,
    output cal_time_t nxt
);
    logic       leap;
    logic [4:0] mlen;
    int         full_year;

    always_comb begin
        full_year = BASE_YEAR + int'(cur.year);
        leap = ((full_year % 4) == 0) &&
               (((full_year % 100) != 0) || ((full_year % 400) == 0));
        unique case (cur.mon)
            4'd2:                      mlen = leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   mlen = 5'd30;
            default:                   mlen = 5'd31;
        endcase
    end

    always_comb begin
        nxt = cur;
        if (cur.sec >= 6'd59) begin
            nxt.sec = 6'd0;
            if (cur.min >= 6'd59) begin
                nxt.min = 6'd0;
                if (cur.hour >= 5'd23) begin
                    nxt.hour = 5'd0;
                    nxt.wday = (cur.wday >= 3'd7) ? 3'd1 : cur.wday + 3'd1;
                    if (cur.mday >= mlen) begin
                        nxt.mday = 5'd1;
                        if (cur.mon >= 4'd12) begin
                            nxt.mon  = 4'd1;
                            nxt.year = (cur.year >= 7'd99) ? 7'd0 : cur.year + 7'd1;
                        end else begin
                            nxt.mon = cur.mon + 4'd1;
                        end
                    end else begin
                        nxt.mday = cur.mday + 5'd1;
                    end
                end else begin
                    nxt.hour = cur.hour + 5'd1;
                end
            end else begin
                nxt.min = cur.min + 6'd1;
            end
        end else begin
            nxt.sec = cur.sec + 6'd1;
        end
    end
endmodule

// File: rtl/cal_codec.sv
module cal_codec
    import cal_pkg::*;
(
    input  cal_time_t  t,
    input  logic       bin,
    input  logic       h24,
    output logic [7:0] fld [NUM_FLD]
);
    logic [6:0] raw [NUM_FLD];
    logic [4:0] h12;

    always_comb begin
        raw[FLD_SEC]  = 7'(t.sec);
        raw[FLD_MIN]  = 7'(t.min);
        raw[FLD_HOUR] = 7'(t.hour);
        raw[FLD_WDAY] = 7'(t.wday);
        raw[FLD_MDAY] = 7'(t.mday);
        raw[FLD_MON]  = 7'(t.mon);
        raw[FLD_YEAR] = t.year;
        h12 = (t.hour % 5'd12 == 5'd0) ? 5'd12 : (t.hour % 5'd12);
    end

    for (genvar g = 0; g < NUM_FLD; g++) begin : g_fld
        if (g == FLD_HOUR) begin : g_hour
            always_comb begin
                if (h24) fld[g] = enc_val(raw[g], bin);
                else     fld[g] = enc_val(7'(h12), bin) | {(t.hour >= 5'd12), 7'd0};
            end
        end else begin : g_plain
            always_comb fld[g] = enc_val(raw[g], bin);
        end
    end
endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
    import cal_pkg::*;
#(
    parameter int N = 3
) (
    input  logic [7:0] alm [N],
    input  logic [7:0] cur [N],
    output logic       match
);
    logic [N-1:0] hit;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit[i] = (alm[i][7:6] == DONT_CARE) || (alm[i] == cur[i]);
    end

    assign match = &hit;
endmodule

// File: rtl/cal_time_counter.sv
module cal_time_counter
    import cal_pkg::*;
#(
    parameter int UIP_CYCLES = 8,
    parameter int BASE_YEAR  = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic       ctl_set,
    input  logic       ctl_binary,
    input  logic       ctl_24h,
    input  logic       ctl_alarm_en,
    input  logic       ctl_upd_en,
    input  logic [2:0] osc_sel,
    input  logic       wr_en,
    input  logic [2:0] wr_field,
    input  logic [7:0] wr_data,
    input  logic [7:0] alm_sec,
    input  logic [7:0] alm_min,
    input  logic [7:0] alm_hour,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] wday_o,
    output logic [7:0] mday_o,
    output logic [7:0] mon_o,
    output logic [7:0] year_o,
    output logic       uip_o,
    output logic [7:0] evt_flags
);
    localparam int CNT_W = $clog2(UIP_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(UIP_CYCLES - 1);

    cal_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    cal_time_t        cur_q, nxt_t, wr_t;
    logic [7:0]       fld [NUM_FLD];
    logic [7:0]       alm_v [3];
    logic [7:0]       now_v [3];
    logic             alarm_hit;
    logic             run_ok;
    logic             commit;
    logic [6:0]       wr_dec;
    logic [6:0]       wr_h12;
    logic [6:0]       wr_hour;

    cal_rollover #(.BASE_YEAR(BASE_YEAR)) u_roll (
        .cur (cur_q),
        .nxt (nxt_t)
    );

    cal_codec u_codec (
        .t   (cur_q),
        .bin (ctl_binary),
        .h24 (ctl_24h),
        .fld (fld)
    );

    assign alm_v[0] = alm_sec;
    assign alm_v[1] = alm_min;
    assign alm_v[2] = alm_hour;
    assign now_v[0] = fld[FLD_SEC];
    assign now_v[1] = fld[FLD_MIN];
    assign now_v[2] = fld[FLD_HOUR];

    cal_alarm_cmp #(.N(3)) u_alarm (
        .alm   (alm_v),
        .cur   (now_v),
        .match (alarm_hit)
    );

    assign run_ok = (osc_sel == OSC_RUN) && !ctl_set;
    assign commit = (state_q == ST_UPD) && !ctl_set && (cnt_q == CNT_LAST);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (sec_tick && run_ok) state_d = ST_UPD;
            ST_UPD: begin
                if (ctl_set)                 state_d = ST_IDLE;
                else if (cnt_q == CNT_LAST)  state_d = ST_POST;
            end
            ST_POST: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_d == ST_UPD && state_q == ST_UPD) ? cnt_q + 1'b1 : '0;
        end
    end

    // write decode in the current encoding
    always_comb begin
        wr_dec  = dec_val(wr_data, ctl_binary);
        wr_h12  = dec_val({1'b0, wr_data[6:0]}, ctl_binary);
        wr_hour = ((wr_h12 == 7'd12) ? 7'd0 : wr_h12) + (wr_data[7] ? 7'd12 : 7'd0);
        wr_t    = commit ? nxt_t : cur_q;
        unique case (int'(wr_field))
            FLD_SEC:  wr_t.sec  = wr_dec[5:0];
            FLD_MIN:  wr_t.min  = wr_dec[5:0];
            FLD_HOUR: wr_t.hour = ctl_24h ? wr_dec[4:0] : wr_hour[4:0];
            FLD_WDAY: wr_t.wday = wr_dec[2:0];
            FLD_MDAY: wr_t.mday = wr_dec[4:0];
            FLD_MON:  wr_t.mon  = wr_dec[3:0];
            FLD_YEAR: wr_t.year = wr_dec;
            default:  wr_t      = wr_t;
        endcase
    end

    // time register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{sec: 6'd0, min: 6'd0, hour: 5'd0, wday: 3'd1,
                       mday: 5'd1, mon: 4'd1, year: 7'd0};
        end else if (wr_en) begin
            cur_q <= wr_t;
        end else if (commit) begin
            cur_q <= nxt_t;
        end
    end

    // outputs
    always_comb begin
        sec_o     = fld[FLD_SEC];
        min_o     = fld[FLD_MIN];
        hour_o    = fld[FLD_HOUR];
        wday_o    = fld[FLD_WDAY];
        mday_o    = fld[FLD_MDAY];
        mon_o     = fld[FLD_MON];
        year_o    = fld[FLD_YEAR];
        uip_o     = (state_q == ST_UPD);
        evt_flags = 8'h00;
        if (state_q == ST_POST) begin
            if (ctl_alarm_en && alarm_hit) evt_flags = evt_flags | EVT_ALARM;
            if (ctl_upd_en)                evt_flags = evt_flags | EVT_UPD;
        end
    end
endmodule

// File: rtl/cal_time_counter_chk.sv
module cal_time_counter_chk
    import cal_pkg::*;
#(
    parameter int UIP_CYCLES = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sec_tick,
    input logic       ctl_set,
    input logic       ctl_alarm_en,
    input logic       ctl_upd_en,
    input logic [2:0] osc_sel,
    input logic       wr_en,
    input logic [5:0] sec_bin,
    input logic       uip_o,
    input logic [7:0] evt_flags
);
    int busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) busy_run <= 0;
        else        busy_run <= uip_o ? busy_run + 1 : 0;
    end

    // R9
    uip_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uip_o) |-> $past(sec_tick && !ctl_set && osc_sel == OSC_RUN));

    // R9
    uip_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= UIP_CYCLES);

    // R8
    set_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_set |=> !uip_o);

    // R7
    time_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!uip_o && !wr_en) |=> $stable(sec_bin));

    // R10
    flag_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_flags != 8'h00) |-> (evt_flags[7] && (evt_flags[5] || evt_flags[4])));

    // R10
    alarm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_flags[5] |-> ctl_alarm_en);

    // R11
    upd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_flags[4] |-> (ctl_upd_en && $fell(uip_o)));
endmodule

bind cal_time_counter cal_time_counter_chk #(.UIP_CYCLES(UIP_CYCLES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sec_tick     (sec_tick),
    .ctl_set      (ctl_set),
    .ctl_alarm_en (ctl_alarm_en),
    .ctl_upd_en   (ctl_upd_en),
    .osc_sel      (osc_sel),
    .wr_en        (wr_en),
    .sec_bin      (cur_q.sec),
    .uip_o        (uip_o),
    .evt_flags    (evt_flags)
);

// File: tb/cal_time_counter_tb.sv
module cal_time_counter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int UIPC       = 8;

    localparam int S_SEC = 0, S_MIN = 1, S_HOUR = 2, S_WDAY = 3, S_MDAY = 4,
                   S_MON = 5, S_YEAR = 6, S_UIP = 7, S_FLAGS = 8, S_ULEN = 9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic       ctl_set = 1'b0;
    logic       ctl_binary = 1'b0;
    logic       ctl_24h = 1'b1;
    logic       ctl_alarm_en = 1'b0;
    logic       ctl_upd_en = 1'b0;
    logic [2:0] osc_sel = 3'b010;
    logic       wr_en = 1'b0;
    logic [2:0] wr_field = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] alm_sec = 8'hC0;
    logic [7:0] alm_min = 8'hC0;
    logic [7:0] alm_hour = 8'hC0;
    logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o, evt_flags;
    logic       uip_o;

    logic [7:0] cap_flags = 8'd0;
    int         cap_ulen = 0;
    int         n_cmp = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    typedef struct {
        string      tag;
        int         sel;
        logic [7:0] exp;
    } exp_item_t;

    exp_item_t sb_q[$];

    cal_time_counter #(.UIP_CYCLES(UIPC), .BASE_YEAR(2000)) u_dut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .ctl_set(ctl_set),
        .ctl_binary(ctl_binary), .ctl_24h(ctl_24h), .ctl_alarm_en(ctl_alarm_en),
        .ctl_upd_en(ctl_upd_en), .osc_sel(osc_sel), .wr_en(wr_en),
        .wr_field(wr_field), .wr_data(wr_data), .alm_sec(alm_sec),
        .alm_min(alm_min), .alm_hour(alm_hour), .sec_o(sec_o), .min_o(min_o),
        .hour_o(hour_o), .wday_o(wday_o), .mday_o(mday_o), .mon_o(mon_o),
        .year_o(year_o), .uip_o(uip_o), .evt_flags(evt_flags)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] observe(input int sel);
        case (sel)
            S_SEC:   return sec_o;
            S_MIN:   return min_o;
            S_HOUR:  return hour_o;
            S_WDAY:  return wday_o;
            S_MDAY:  return mday_o;
            S_MON:   return mon_o;
            S_YEAR:  return year_o;
            S_UIP:   return {7'd0, uip_o};
            S_FLAGS: return cap_flags;
            default: return 8'(cap_ulen);
        endcase
    endfunction

    // monitor: pops expectations and compares against the design
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() != 0) begin
                exp_item_t it;
                logic [7:0] act;
                it  = sb_q.pop_front();
                act = observe(it.sel);
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual 0x%02h expected 0x%02h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic expect_v(input int sel, input logic [7:0] exp, input string tag);
        exp_item_t it;
        it.tag = tag; it.sel = sel; it.exp = exp;
        sb_q.push_back(it);
    endtask

    task automatic drain();
        wait (sb_q.size() == 0);
        @(negedge clk);
    endtask

    task automatic wr(input int f, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_field = 3'(f); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_time(input logic [7:0] y, mo, md, wd, h, mi, s);
        wr(S_YEAR, y); wr(S_MON, mo); wr(S_MDAY, md); wr(S_WDAY, wd);
        wr(S_HOUR, h); wr(S_MIN, mi); wr(S_SEC, s);
    endtask

    task automatic one_second();
        @(negedge clk);
        sec_tick = 1'b1;
        cap_flags = 8'd0;
        cap_ulen  = 0;
        @(negedge clk);
        sec_tick = 1'b0;
        if (uip_o) cap_ulen++;
        for (int i = 0; i < UIPC + 3; i++) begin
            @(negedge clk);
            if (uip_o) cap_ulen++;
            cap_flags = cap_flags | evt_flags;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        expect_v(S_SEC, 8'h00, "R12 reset sec");
        expect_v(S_HOUR, 8'h00, "R4 reset hour");
        expect_v(S_MDAY, 8'h01, "R6 reset mday");
        expect_v(S_WDAY, 8'h01, "R5 reset wday");
        expect_v(S_UIP, 8'h00, "R9 reset uip");
        drain();

        // R1 R4 R5 R6: full ripple at year end, packed decimal 24h
        set_time(8'h23, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59);
        expect_v(S_HOUR, 8'h23, "R12 written hour");
        drain();
        one_second();
        expect_v(S_ULEN, 8'(UIPC), "R9 uip width");
        expect_v(S_SEC, 8'h00, "R1 sec wrap");
        expect_v(S_MIN, 8'h00, "R4 min wrap");
        expect_v(S_HOUR, 8'h00, "R4 hour wrap");
        expect_v(S_WDAY, 8'h01, "R5 wday wrap");
        expect_v(S_MDAY, 8'h01, "R6 mday wrap");
        expect_v(S_MON, 8'h01, "R6 mon wrap");
        expect_v(S_YEAR, 8'h24, "R1 year carry decimal");
        expect_v(S_FLAGS, 8'h00, "R11 no flags when disabled");
        drain();

        // R6 leap year 2024
        set_time(8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
        one_second();
        expect_v(S_MDAY, 8'h29, "R6 leap Feb 29");
        expect_v(S_MON, 8'h02, "R6 leap stays Feb");
        expect_v(S_WDAY, 8'h04, "R5 wday step");
        drain();
        set_time(8'h24, 8'h02, 8'h29, 8'h04, 8'h23, 8'h59, 8'h59);
        one_second();
        expect_v(S_MON, 8'h03, "R6 leap Feb end");
        drain();
        // R6 plain year 2023
        set_time(8'h23, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
        one_second();
        expect_v(S_MDAY, 8'h01, "R6 plain Feb end mday");
        expect_v(S_MON, 8'h03, "R6 plain Feb end mon");
        drain();
        // R6 century year 2000 is leap
        set_time(8'h00, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
        one_second();
        expect_v(S_MDAY, 8'h29, "R6 year 2000 leap");
        drain();
        // R6 30-day month
        set_time(8'h10, 8'h04, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59);
        one_second();
        expect_v(S_MDAY, 8'h01, "R6 April end mday");
        expect_v(S_MON, 8'h05, "R6 April end mon");
        drain();
        // R6 year 99 wraps to 0
        set_time(8'h99, 8'h12, 8'h31, 8'h01, 8'h23, 8'h59, 8'h59);
        one_second();
        expect_v(S_YEAR, 8'h00, "R6 year wrap");
        drain();

        // R3 12-hour mode
        ctl_24h = 1'b0;
        @(negedge clk);
        expect_v(S_HOUR, 8'h12, "R3 midnight reads 12 AM");
        drain();
        set_time(8'h10, 8'h05, 8'h01, 8'h01, 8'h91, 8'h59, 8'h59);
        one_second();
        expect_v(S_HOUR, 8'h12, "R3 11PM to 12AM");
        expect_v(S_MDAY, 8'h02, "R3 day step at midnight");
        drain();
        wr(S_HOUR, 8'h11); wr(S_MIN, 8'h59); wr(S_SEC, 8'h59);
        one_second();
        expect_v(S_HOUR, 8'h92, "R3 11AM to 12PM");
        drain();
        wr(S_MIN, 8'h59); wr(S_SEC, 8'h59);
        one_second();
        expect_v(S_HOUR, 8'h81, "R3 12PM to 1PM");
        drain();
        ctl_24h = 1'b1;
        @(negedge clk);
        expect_v(S_HOUR, 8'h13, "R4 same hour in 24h");
        drain();

        // R2 binary encoding
        ctl_binary = 1'b1;
        wr(S_MIN, 8'd10); wr(S_SEC, 8'd59); wr(S_HOUR, 8'd20);
        expect_v(S_HOUR, 8'h14, "R2 binary hour write");
        drain();
        one_second();
        expect_v(S_SEC, 8'h00, "R2 binary sec wrap");
        expect_v(S_MIN, 8'h0B, "R2 binary minute");
        drain();
        ctl_binary = 1'b0;
        @(negedge clk);
        expect_v(S_MIN, 8'h11, "R2 re-encode to decimal");
        drain();

        // R7 oscillator gate
        wr(S_SEC, 8'h30);
        osc_sel = 3'b000;
        one_second();
        expect_v(S_SEC, 8'h30, "R7 osc off no advance");
        expect_v(S_ULEN, 8'h00, "R7 osc off no uip");
        drain();
        osc_sel = 3'b011;
        one_second();
        expect_v(S_SEC, 8'h30, "R7 other osc code no advance");
        drain();
        osc_sel = 3'b010;

        // R8 hold bit
        ctl_set = 1'b1;
        one_second();
        expect_v(S_SEC, 8'h30, "R8 held no advance");
        expect_v(S_ULEN, 8'h00, "R8 held no uip");
        drain();
        wr(S_SEC, 8'h45);
        expect_v(S_SEC, 8'h45, "R12 write while held");
        drain();
        ctl_set = 1'b0;
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        expect_v(S_UIP, 8'h01, "R9 uip after strobe");
        drain();
        ctl_set = 1'b1;
        @(negedge clk);
        expect_v(S_UIP, 8'h00, "R8 set drops uip");
        drain();
        ctl_set = 1'b0;
        repeat (UIPC + 2) @(negedge clk);
        expect_v(S_SEC, 8'h45, "R8 aborted update no advance");
        drain();

        // R10 alarm with don't-care
        ctl_alarm_en = 1'b1;
        alm_sec = 8'h05; alm_min = 8'hC0; alm_hour = 8'hFF;
        wr(S_SEC, 8'h04);
        one_second();
        expect_v(S_FLAGS, 8'hA0, "R10 alarm match");
        drain();
        one_second();
        expect_v(S_FLAGS, 8'h00, "R10 alarm mismatch");
        drain();
        alm_hour = 8'h07;
        wr(S_SEC, 8'h04);
        one_second();
        expect_v(S_FLAGS, 8'h00, "R10 hour byte blocks");
        drain();
        ctl_alarm_en = 1'b0;
        alm_hour = 8'hC0;
        wr(S_SEC, 8'h04);
        one_second();
        expect_v(S_FLAGS, 8'h00, "R10 alarm disabled");
        drain();

        // R11 update-finished flag
        ctl_upd_en = 1'b1;
        one_second();
        expect_v(S_FLAGS, 8'h90, "R11 update flag");
        drain();
        ctl_alarm_en = 1'b1;
        wr(S_SEC, 8'h04);
        one_second();
        expect_v(S_FLAGS, 8'hB0, "R11 both flags");
        drain();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule